// File: doc/BRIEF.md
# Configuration image header parser

This block scans a configuration image as it streams in, one byte per accepted beat, starting at offset zero. From the header it learns where the block lookup table sits. From the table it finds two blocks: the component-size table and the bitstream payload. It then adds up the packed component sizes and reports where the payload starts and how many bytes it holds. A loader uses these two numbers to decide which part of the stream to forward to the configuration port.

A start pulse loads the total image length and clears all parse state. Bytes are then offered on a valid/ready pair. The parser accepts bytes until it has what it needs, then drops ready. It either pulses both result strobes once or raises a sticky error flag. The parser only looks ahead: each offset it learns is compared with a running byte counter. Data that lies behind the counter can no longer be read, so such an offset is an error.

Top module: `img_hdr_parser`

## Requirements
- R1: The byte at offset 24 is the header size H. Parsing fails if H exceeds the image length, or if H < 26, which would put the record-count byte at or before offset 24. The byte at offset H-1 is the record count N.
- R2: Lookup records start at offset H and are 9 bytes long. Byte 0 of a record is the block ID and bytes 1..4 are a little-endian 32-bit block offset. The first record with ID 8 gives the payload start, which is reported on `pay_start_o`; later records with ID 8 are ignored.
- R3: The first record with ID 5 gives the component table start. Parsing fails if N is 0, or if no record carries ID 5 or no record carries ID 8.
- R4: The component count C is a little-endian 16-bit value at offsets 55 (low byte) and 56 (high byte). C is read correctly even when the table ends before offset 56.
- R5: Component sizes are 22-bit fields packed back to back. Field i starts at bit 22·i of the component table, with bits counted LSB first within each byte and bytes in ascending order. `pay_size_o` equals 16 times the sum of the C fields.
- R6: Parsing fails if H + 9·N exceeds the image length. It also fails if the component table start plus ceil(22·C/8) exceeds the image length.
- R7: Parsing fails if the payload start plus the payload size exceeds the image length. Exact equality is accepted.
- R8: Parsing fails if the component table starts at or before the checkpoint byte. The checkpoint is the later of the last lookup byte and offset 56.
- R9: `err_o` stays high until the next start pulse. The two result strobes rise together for exactly one cycle, and never while `err_o` is high.
- R10: `byte_ready_o` is low after reset. It is high from the cycle after a start pulse until the byte that completes or fails the parse has been accepted, and low afterwards.
- R11: A start pulse during a parse abandons that parse and begins a new one at offset 0. Bytes offered in the start cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new parse at offset 0 |
| img_len_i | input | LEN_W | Total image length in bytes, sampled on start |
| byte_i | input | 8 | Image byte |
| byte_valid_i | input | 1 | Byte present |
| byte_ready_o | output | 1 | Parser accepts a byte |
| pay_start_o | output | LEN_W | Payload start offset |
| pay_start_valid_o | output | 1 | One-cycle strobe for pay_start_o |
| pay_size_o | output | SUM_W+4 | Payload size in bytes |
| pay_size_valid_o | output | 1 | One-cycle strobe for pay_size_o |
| err_o | output | 1 | Sticky parse error |

## Verification
The bench builds the parser with the default widths: 32-bit lengths and offsets, a 32-bit size sum, and a 36-bit size output. This lets the image length be set near 2^30 while the streamed bytes stay within a 512-byte buffer. As a result, fields with all 22 bits set, and fields spread across three bytes, can be summed without the payload-fit check hiding them. The exact-fit and one-short length cases for the payload and for both tables are computed from the image itself. A header placed low makes the checkpoint fall on offset 56, so the count's high byte arrives in the same beat as the decision that uses it.

// File: rtl/imgp_pkg.sv
package imgp_pkg;
  localparam int HDR_AT      = 24;
  localparam int CNT_AT      = 55;
  localparam int MIN_HDR     = HDR_AT + 2;
  localparam int REC_BYTES   = 9;
  localparam int COMP_ID     = 5;
  localparam int PAY_ID      = 8;
  localparam int FIELD_W     = 22;
  localparam int FRAME_SHIFT = 4;
endpackage

// File: rtl/imgp_lut_walk.sv
module imgp_lut_walk
  import imgp_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [7:0]       byte_i,
  output logic [LEN_W-1:0] comp_at_o,
  output logic [LEN_W-1:0] pay_at_o,
  output logic             comp_hit_o,
  output logic             pay_hit_o
);
  localparam int KW = $clog2(REC_BYTES);

  logic [KW-1:0] k_q;
  logic [7:0]    id_q;
  logic [23:0]   off_sr_q;
  logic [31:0]   off_w;

  assign off_w = {byte_i, off_sr_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q <= '0; id_q <= '0; off_sr_q <= '0;
      comp_at_o <= '0; pay_at_o <= '0; comp_hit_o <= 1'b0; pay_hit_o <= 1'b0;
    end else if (clr_i) begin
      k_q <= '0; id_q <= '0; off_sr_q <= '0;
      comp_at_o <= '0; pay_at_o <= '0; comp_hit_o <= 1'b0; pay_hit_o <= 1'b0;
    end else if (en_i) begin
      k_q <= (k_q == KW'(REC_BYTES - 1)) ? '0 : k_q + 1'b1;
      if (k_q == '0) id_q <= byte_i;
      if (k_q >= KW'(1) && k_q <= KW'(3)) off_sr_q <= {byte_i, off_sr_q[23:8]};
      if (k_q == KW'(4)) begin
        // first match wins
        if (id_q == 8'(COMP_ID) && !comp_hit_o) begin
          comp_at_o  <= LEN_W'(off_w);
          comp_hit_o <= 1'b1;
        end
        if (id_q == 8'(PAY_ID) && !pay_hit_o) begin
          pay_at_o  <= LEN_W'(off_w);
          pay_hit_o <= 1'b1;
        end
      end
    end
  end

  p_rec_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_q < KW'(REC_BYTES));
  p_hit_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_hit_o && !clr_i |=> pay_hit_o && $stable(pay_at_o));
endmodule

// File: rtl/imgp_field_acc.sv
module imgp_field_acc
  import imgp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic [7:0]         byte_i,
  output logic               done_o,
  output logic [FIELD_W-1:0] field_o
);
  localparam int ACC_W = FIELD_W + 8;
  localparam int NB_W  = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] acc_q, wide;
  logic [NB_W-1:0]  nb_q, nb_sum;

  always_comb begin
    wide    = acc_q | (ACC_W'(byte_i) << nb_q);
    nb_sum  = nb_q + NB_W'(8);
    done_o  = nb_sum >= NB_W'(FIELD_W);
    field_o = wide[FIELD_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0; nb_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0; nb_q <= '0;
    end else if (en_i) begin
      if (done_o) begin
        acc_q <= wide >> FIELD_W;
        nb_q  <= nb_sum - NB_W'(FIELD_W);
      end else begin
        acc_q <= wide;
        nb_q  <= nb_sum;
      end
    end
  end

  p_nbits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nb_q < NB_W'(FIELD_W));
endmodule

// File: rtl/img_hdr_parser.sv
module img_hdr_parser
  import imgp_pkg::*;
#(
  parameter int LEN_W  = 32,
  parameter int SUM_W  = 32,
  localparam int SIZE_W = SUM_W + FRAME_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  img_len_i,
  input  logic [7:0]        byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic [LEN_W-1:0]  pay_start_o,
  output logic              pay_start_valid_o,
  output logic [SIZE_W-1:0] pay_size_o,
  output logic              pay_size_valid_o,
  output logic              err_o
);
  localparam int CW = ((SIZE_W > LEN_W) ? SIZE_W : LEN_W) + 2;

  logic              busy_q, err_q, fin_q, hdr_seen_q, tbl_known_q, checked_q;
  logic [LEN_W-1:0]  pos_q, len_q, tbl_end_q, chk_q, pay_start_q;
  logic [7:0]        hdr_q;
  logic [15:0]       cnt_q, left_q, cnt_now;
  logic [SUM_W-1:0]  sum_q, sum_nx, sum_fin;
  logic [SIZE_W-1:0] pay_size_q, size_w;
  logic [LEN_W-1:0]  comp_at, pay_at;
  logic              comp_hit, pay_hit, fld_done;
  logic [FIELD_W-1:0] fld;
  logic              acc_b, is_hdr, is_nrec, in_tbl, is_chk, in_comp, fin_now, err_now;
  logic              hdr_bad, nrec_bad, chk_bad, fin_bad, end_bad;
  logic [CW-1:0]     len_w, tend_w, tbl_bytes_w;

  always_comb begin
    acc_b    = busy_q & byte_valid_i & ~start_i;
    len_w    = CW'(len_q);
    is_hdr   = acc_b && pos_q == LEN_W'(HDR_AT);
    hdr_bad  = is_hdr && (CW'(byte_i) > len_w || byte_i < 8'(MIN_HDR));
    is_nrec  = acc_b && hdr_seen_q && !tbl_known_q && pos_q == LEN_W'(hdr_q) - 1'b1;
    tend_w   = CW'(hdr_q) + CW'(byte_i) * CW'(REC_BYTES);
    nrec_bad = is_nrec && (tend_w > len_w || byte_i == 8'd0);
    in_tbl   = acc_b && tbl_known_q && pos_q >= LEN_W'(hdr_q) && pos_q < tbl_end_q;
    is_chk   = acc_b && tbl_known_q && !checked_q && pos_q == chk_q;
    // high count byte may arrive in the checkpoint beat itself
    cnt_now  = (pos_q == LEN_W'(CNT_AT + 1)) ? {byte_i, cnt_q[7:0]} : cnt_q;
    tbl_bytes_w = (CW'(cnt_now) * CW'(FIELD_W) + CW'(7)) >> 3;
    chk_bad  = is_chk && (!comp_hit || !pay_hit || comp_at <= pos_q ||
                          CW'(comp_at) + tbl_bytes_w > len_w);
    in_comp  = acc_b && checked_q && left_q != 16'd0 && pos_q >= comp_at;
    sum_nx   = sum_q + SUM_W'(fld);
    fin_now  = 1'b0;
    sum_fin  = '0;
    if (is_chk && cnt_now == 16'd0) fin_now = 1'b1;
    else if (in_comp && fld_done && left_q == 16'd1) begin
      fin_now = 1'b1;
      sum_fin = sum_nx;
    end
    size_w   = SIZE_W'(sum_fin) << FRAME_SHIFT;
    fin_bad  = fin_now && CW'(pay_at) + CW'(size_w) > len_w;
    end_bad  = acc_b && pos_q == len_q - 1'b1 && !fin_now;
    err_now  = hdr_bad | nrec_bad | chk_bad | fin_bad | end_bad;
  end

  imgp_lut_walk #(.LEN_W(LEN_W)) u_walk (
    .clk_i, .rst_ni, .clr_i(start_i), .en_i(in_tbl), .byte_i,
    .comp_at_o(comp_at), .pay_at_o(pay_at), .comp_hit_o(comp_hit), .pay_hit_o(pay_hit)
  );

  imgp_field_acc u_acc (
    .clk_i, .rst_ni, .clr_i(start_i), .en_i(in_comp), .byte_i,
    .done_o(fld_done), .field_o(fld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; err_q <= 1'b0; fin_q <= 1'b0; hdr_seen_q <= 1'b0;
      tbl_known_q <= 1'b0; checked_q <= 1'b0; pos_q <= '0; len_q <= '0;
      tbl_end_q <= '0; chk_q <= '0; hdr_q <= '0; cnt_q <= '0; left_q <= '0;
      sum_q <= '0; pay_start_q <= '0; pay_size_q <= '0;
    end else begin
      fin_q <= 1'b0;
      if (start_i) begin
        busy_q <= img_len_i != '0;
        err_q  <= img_len_i == '0;
        len_q  <= img_len_i;
        pos_q  <= '0; hdr_seen_q <= 1'b0; tbl_known_q <= 1'b0; checked_q <= 1'b0;
        tbl_end_q <= '0; chk_q <= '0; hdr_q <= '0; cnt_q <= '0; left_q <= '0; sum_q <= '0;
      end else if (acc_b) begin
        pos_q <= pos_q + 1'b1;
        if (is_hdr) begin
          hdr_q <= byte_i;
          hdr_seen_q <= 1'b1;
        end
        if (pos_q == LEN_W'(CNT_AT))     cnt_q[7:0]  <= byte_i;
        if (pos_q == LEN_W'(CNT_AT + 1)) cnt_q[15:8] <= byte_i;
        if (is_nrec) begin
          tbl_known_q <= 1'b1;
          tbl_end_q   <= LEN_W'(tend_w);
          chk_q <= (tend_w - CW'(1) > CW'(CNT_AT + 1)) ? LEN_W'(tend_w - CW'(1))
                                                       : LEN_W'(CNT_AT + 1);
        end
        if (is_chk) begin
          checked_q <= 1'b1;
          left_q    <= cnt_now;
        end
        if (in_comp && fld_done) begin
          sum_q  <= sum_nx;
          left_q <= left_q - 1'b1;
        end
        if (err_now) begin
          err_q  <= 1'b1;
          busy_q <= 1'b0;
        end else if (fin_now) begin
          fin_q       <= 1'b1;
          busy_q      <= 1'b0;
          pay_start_q <= pay_at;
          pay_size_q  <= size_w;
        end
      end
    end
  end

  assign byte_ready_o      = busy_q;
  assign err_o             = err_q;
  assign pay_start_o       = pay_start_q;
  assign pay_size_o        = pay_size_q;
  assign pay_start_valid_o = fin_q;
  assign pay_size_valid_o  = fin_q;

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> err_o);
  p_no_strobe_on_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_start_valid_o |-> !err_o);
  p_strobe_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_size_valid_o |=> !pay_size_valid_o);
  p_idle_on_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !byte_ready_o);
  p_idle_on_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_start_valid_o |-> !byte_ready_o);
  p_payload_fits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_size_valid_o |-> CW'(pay_start_o) + CW'(pay_size_o) <= CW'(len_q));
  p_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> pos_q == '0 && !err_o || img_len_i == '0);
endmodule

// File: tb/img_hdr_parser_tb_top.sv
module img_hdr_parser_tb_top;
  localparam int LEN_W = 32;
  localparam int SUM_W = 32;
  localparam int SIZE_W = SUM_W + 4;
  localparam int BUF = 512;
  localparam int LB = 32'h4000_0000;

  typedef struct packed {
    int hdr; int nrec; int r5; int r8; int r8b; int comp; int pay;
    int cnt; int seed; int len; int mode; int xerr; int req;
  } case_t;

  localparam int NC = 15;
  localparam case_t CASES [NC] = '{
    '{60, 3, 0, 2, -1, 100, 150, 3, 1, LB,   0, 0, 5},  // R1 R5 baseline
    '{60, 4, 3, 1,  2, 120, 200, 7, 2, LB,   0, 0, 2},  // R2 duplicate id 8 ignored
    '{30, 2, 1, 0, -1,  57,   9, 1, 3, LB,   0, 0, 4},  // R4 checkpoint on offset 56
    '{60, 2, 0, 1, -1,  90,   5, 0, 4, 1000, 0, 0, 5},  // R5 zero components
    '{60, 3,-1, 1, -1, 100, 150, 2, 5, LB,   0, 1, 3},  // R3 no id 5
    '{60, 3, 0,-1, -1, 100, 150, 2, 5, LB,   0, 1, 3},  // R3 no id 8
    '{60, 3, 0, 1, -1, 100, 150, 2, 5, 59,   0, 1, 1},  // R1 header beyond image
    '{20, 3, 0, 1, -1, 100, 150, 2, 5, LB,   0, 1, 1},  // R1 header too small
    '{60, 3, 0, 1, -1, 100, 150, 2, 5, 86,   0, 1, 6},  // R6 lookup overrun
    '{60, 3, 0, 1, -1, 100, 150, 3, 5, 108,  0, 1, 6},  // R6 component table overrun
    '{60, 3, 0, 1, -1, 100, 150, 3, 5, 109,  0, 1, 7},  // R7 comp table fits, payload not
    '{60, 3, 0, 1, -1,  80, 150, 2, 5, LB,   0, 1, 8},  // R8 table behind checkpoint
    '{60, 3, 0, 1, -1, 100, 150, 4, 6, 0,    1, 0, 7},  // R7 exact fit
    '{60, 3, 0, 1, -1, 100, 150, 4, 6, 0,    2, 1, 7},  // R7 one short
    '{60, 0, 0, 1, -1, 100, 150, 2, 5, LB,   0, 1, 3}   // R3 empty table
  };

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, byte_valid_i = 1'b0;
  logic [LEN_W-1:0] img_len_i = '0;
  logic [7:0] byte_i = '0;
  logic byte_ready_o, pay_start_valid_o, pay_size_valid_o, err_o;
  logic [LEN_W-1:0] pay_start_o;
  logic [SIZE_W-1:0] pay_size_o;

  logic [7:0] img [BUF];
  int checks = 0, errs = 0, n_s = 0, n_z = 0;
  longint got_s, got_z;
  bit done = 1'b0;

  always #5 clk = ~clk;

  img_hdr_parser #(.LEN_W(LEN_W), .SUM_W(SUM_W)) dut_i (.*, .clk_i(clk));

  always @(negedge clk) begin
    if (pay_start_valid_o) begin n_s++; got_s = pay_start_o; end
    if (pay_size_valid_o) begin n_z++; got_z = pay_size_o; end
  end

  task automatic chk(input bit ok, input int req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint fval(int seed, int i);
    longint v = ((longint'(seed) * 64'h9E3779B1 + longint'(i) * 64'h7F4A7C15) >> 7) & 64'h3F_FFFF;
    if (seed == 2 && i == 0) v = 64'h3F_FFFF;
    return v;
  endfunction

  task automatic run_case(input int ci, input int abort_at);
    case_t c = CASES[ci];
    longint sum = 0, len;
    int pos = 0, cyc = 0, guard = 0;
    bit acc;
    for (int k = 0; k < BUF; k++) img[k] = 8'((k * 13 + 5) ^ 8'hA6);
    for (int r = 0; r < c.nrec; r++) begin
      int b = c.hdr + 9 * r;
      int id = (r == c.r5) ? 5 : (r == c.r8 || r == c.r8b) ? 8 : 3;
      int off = (r == c.r5) ? c.comp : (r == c.r8) ? c.pay : (r == c.r8b) ? c.pay + 1000 : 32'h1234 + r;
      img[b] = 8'(id);
      for (int j = 0; j < 4; j++) img[b + 1 + j] = 8'(off >> (8 * j));
    end
    for (int j = 0; j < (c.cnt * 22 + 7) / 8; j++) img[c.comp + j] = 8'h00;
    for (int i = 0; i < c.cnt; i++) begin
      longint v = fval(c.seed, i);
      sum += v;
      for (int b = 0; b < 22; b++) begin
        int g = i * 22 + b;
        img[c.comp + g / 8][g % 8] = v[b];
      end
    end
    img[55] = 8'(c.cnt);
    img[56] = 8'(c.cnt >> 8);
    img[c.hdr - 1] = 8'(c.nrec);
    img[24] = 8'(c.hdr);
    len = (c.mode == 0) ? longint'(c.len) : c.pay + 16 * sum - ((c.mode == 2) ? 1 : 0);

    @(negedge clk);
    start_i = 1'b1; img_len_i = LEN_W'(len); byte_valid_i = 1'b0;
    n_s = 0; n_z = 0;
    @(negedge clk);
    start_i = 1'b0;
    if (abort_at < 0) chk(byte_ready_o == 1'b1, 10, "ready after start", byte_ready_o, 1);
    while (byte_ready_o && guard < 5000) begin
      if (abort_at >= 0 && pos == abort_at) return;
      byte_i = (pos < BUF) ? img[pos] : 8'h00;
      byte_valid_i = (cyc % 5) != 3;
      acc = byte_valid_i;
      @(negedge clk);
      if (acc) pos++;
      cyc++; guard++;
    end
    byte_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(err_o == 1'(c.xerr), c.req, $sformatf("case %0d err", ci), err_o, c.xerr);
    chk(byte_ready_o == 1'b0, 10, $sformatf("case %0d idle", ci), byte_ready_o, 0);
    if (c.xerr == 0) begin
      chk(n_s == 1 && n_z == 1, 9, $sformatf("case %0d strobes", ci), n_s + n_z, 2);
      chk(got_s == c.pay, 2, $sformatf("case %0d start", ci), got_s, c.pay);
      chk(got_z == 16 * sum, 5, $sformatf("case %0d size", ci), got_z, 16 * sum);
    end else begin
      chk(n_s == 0 && n_z == 0, 9, $sformatf("case %0d no strobe", ci), n_s + n_z, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(byte_ready_o == 1'b0, 10, "reset ready", byte_ready_o, 0);
    chk(err_o == 1'b0, 9, "reset err", err_o, 0);
    chk(!pay_start_valid_o && !pay_size_valid_o, 9, "reset strobes", pay_start_valid_o, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < NC; i++) run_case(i, -1);

    // R9: error holds without start, clears on start
    run_case(4, -1);
    repeat (5) @(negedge clk);
    chk(err_o == 1'b1, 9, "sticky err", err_o, 1);
    chk(n_s == 0, 9, "no late strobe", n_s, 0);
    @(negedge clk); start_i = 1'b1; img_len_i = LB;
    @(negedge clk); start_i = 1'b0;
    chk(err_o == 1'b0, 9, "err cleared by start", err_o, 1'b0);
    chk(byte_ready_o == 1'b1, 10, "ready after restart", byte_ready_o, 1);

    // R11: abandon a parse midway, then a full parse must be clean
    run_case(1, 30);
    chk(byte_ready_o == 1'b1, 11, "busy mid parse", byte_ready_o, 1);
    run_case(0, -1);
    run_case(2, 57);
    run_case(3, -1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule